// File: doc/BRIEF.md
# Legacy interrupt line status and clear controller

This block gathers four level-style legacy interrupt lines into a sticky status field that sits at a parameterised bit offset inside a 32-bit status word. A status bit latches on any cycle in which its line is high and stays set until software writes a one to that bit position. A companion enable word, using the same bit positions, decides which latched bits may drive the single combined interrupt output. That output is registered.

Software reads the status word and keeps only the four-bit field. It clears each handled bit on its own by writing a one to it, then reads the word again. It repeats this until the field reads zero. A line that is still asserted sets its bit again, so no event is lost. Masking and unmasking are done by read-modify-write of the enable word. All bits outside the field are reserved: they read as zero and writes to them have no effect.

Top module: `intx_ctrl`

## Requirements
- R1: After reset the status field, the enable field and `irq_o` are all zero.
- R2: A line that is high at a rising clock edge sets its status bit. Line i appears at read bit START_BIT+i when `reg_sel_i` is 0 (status). The default START_BIT is 5, so line 2 reads as 0x80.
- R3: A write with `reg_sel_i` = 0 clears exactly the status bits whose data bit is 1, provided their lines are low. Data bits that are 0 leave their status bits unchanged.
- R4: When a line is high in the same cycle that software writes a one to clear its bit, the bit stays set.
- R5: A write with `reg_sel_i` = 1 loads data bits START_BIT..START_BIT+3 into the enable field. The field reads back at the same positions when `reg_sel_i` is 1.
- R6: `irq_o` is high one cycle after any bit is set in both status and enable, and low one cycle after no such bit exists.
- R7: Read bits outside START_BIT..START_BIT+3 are always zero, whatever was written to them.
- R8: A line whose enable bit is 0 still sets its status bit but never raises `irq_o`.
- R9: A write to the enable word leaves the status field unchanged, and a write to the status word leaves the enable field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_src_i | input | NUM_SRC (4) | Legacy interrupt lines, bit i is line i |
| reg_wr_i | input | 1 | Write strobe for the selected word |
| reg_sel_i | input | 1 | Word select: 0 status, 1 enable |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data of the selected word, combinational |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
Two things can happen to one status bit in the same cycle: a line sets it and a software write clears it. The bench provokes this once on purpose, with line 0 held high while a clear of bit 0 is written. It also provokes it many more times with random line levels mixed with random clear writes. A cycle-accurate model in the bench, in which the set always wins, judges every case by comparing the read data and the one-cycle-late `irq_o` after each edge.

// File: rtl/intx_pkg.sv
package intx_pkg;
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/intx_status_cell.sv
module intx_status_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic clr_i,
    output logic stat_o
);
    typedef struct packed {
        logic stat;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_i) c_d.stat = 1'b0;
        if (src_i) c_d.stat = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign stat_o = c_q.stat;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        src_i |=> stat_o); // R4
    AST_CLEAR_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !src_i) |=> !stat_o); // R3
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !src_i) |=> $stable(stat_o)); // R3
endmodule

// File: rtl/intx_enable_reg.sv
module intx_enable_reg #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] data_i,
    output logic [NUM_SRC-1:0] en_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } en_t;

    en_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (wr_i) e_d.en = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign en_o = e_q.en;

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o)); // R9
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(data_i))); // R5
endmodule

// File: rtl/intx_irq_merge.sv
module intx_irq_merge #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic               irq_o
);
    typedef struct packed {
        logic irq;
    } merge_t;

    merge_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        m_d.irq = |(status_i & enable_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign irq_o = m_q.irq;

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_i & enable_i)) |=> irq_o); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i == '0) |=> !irq_o); // R8
endmodule

// File: rtl/intx_ctrl.sv
module intx_ctrl #(
    parameter int DATA_W    = 32,
    parameter int NUM_SRC   = 4,
    parameter int START_BIT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] intx_src_i,
    input  logic               reg_wr_i,
    input  logic               reg_sel_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);
    import intx_pkg::*;

    localparam logic [DATA_W-1:0] FIELD_MASK =
        {{(DATA_W-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}} << START_BIT;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wr_field;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic               en_wr;
    logic [DATA_W-1:0]  unused_wdata;

    assign sel          = reg_sel_e'(reg_sel_i);
    assign wr_field     = reg_wdata_i[START_BIT +: NUM_SRC];
    assign unused_wdata = reg_wdata_i & ~FIELD_MASK;

    always_comb begin
        clr_vec = '0;
        en_wr   = 1'b0;
        if (reg_wr_i) begin
            if (sel == SEL_STATUS) clr_vec = wr_field;
            else                   en_wr   = 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        intx_status_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (intx_src_i[i]),
            .clr_i  (clr_vec[i]),
            .stat_o (status[i])
        );
    end

    intx_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (en_wr),
        .data_i (wr_field),
        .en_o   (enable)
    );

    intx_irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .enable_i (enable),
        .irq_o    (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (sel == SEL_STATUS) reg_rdata_o[START_BIT +: NUM_SRC] = status;
        else                   reg_rdata_o[START_BIT +: NUM_SRC] = enable;
    end

    AST_STATUS_STABLE_ON_EN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && intx_src_i == '0) |=> $stable(status)); // R9
endmodule

// File: tb/intx_ctrl_tb.sv
module intx_ctrl_tb;
    localparam int DW = 32;
    localparam int N  = 4;
    localparam int SB = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  src;
    logic          wr;
    logic          sel;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [N-1:0] st_m, en_m;
    logic         irq_m;

    always #10 clk = ~clk;   // 50 MHz

    intx_ctrl #(.DATA_W(DW), .NUM_SRC(N), .START_BIT(SB)) u_dut (
        .clk (clk), .rst_n (rst_n), .intx_src_i (src), .reg_wr_i (wr),
        .reg_sel_i (sel), .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_o (irq)
    );

    function automatic logic [DW-1:0] exp_rd(input logic s);
        logic [DW-1:0] v = '0;
        v[SB +: N] = s ? en_m : st_m;
        return v;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [N-1:0] s, input logic w, input logic se,
                       input logic [DW-1:0] d, input string tag);
        logic [N-1:0] clr;
        @(negedge clk);
        src = s; wr = w; sel = se; wdata = d;
        @(posedge clk);
        clr   = (w && !se) ? d[SB +: N] : '0;
        irq_m = |(st_m & en_m);
        st_m  = s | (st_m & ~clr);
        if (w && se) en_m = d[SB +: N];
        #2;
        check(tag, rdata, exp_rd(se));
        check("R6", {31'b0, irq}, {31'b0, irq_m});
    endtask

    task automatic peek(input logic se, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        src = '0; wr = 1'b0; sel = se;
        #1;
        check(tag, rdata, exp);
    endtask

    initial begin
        #(20 * 5000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; src = '0; wr = 1'b0; sel = 1'b0; wdata = '0;
        st_m = '0; en_m = '0; irq_m = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", rdata, '0);
        check("R1", {31'b0, irq}, 32'd0);
        sel = 1'b1; #1;
        check("R1", rdata, '0);
        @(negedge clk); rst_n = 1'b1;

        // R2: line 2 pulse latches at bit 7
        cyc(4'b0100, 1'b0, 1'b0, '0, "R2");
        cyc(4'b0000, 1'b0, 1'b0, '0, "R2");
        check("R2", rdata, 32'h0000_0080);
        // R3: writing zeros keeps, writing one clears
        cyc(4'b0000, 1'b1, 1'b0, 32'hFFFF_FF7F, "R3");
        check("R3", rdata, 32'h0000_0080);
        cyc(4'b0000, 1'b1, 1'b0, 32'h0000_0080, "R3");
        check("R3", rdata, 32'h0000_0000);
        // R4: set and clear together, set wins
        cyc(4'b0001, 1'b1, 1'b0, 32'h0000_0020, "R4");
        check("R4", rdata, 32'h0000_0020);
        // R5 / R7: enable write with all ones reads back field only
        cyc(4'b0000, 1'b1, 1'b1, 32'hFFFF_FFFF, "R5");
        check("R7", rdata, 32'h0000_01E0);
        // R9: status unchanged by enable write
        peek(1'b0, 32'h0000_0020, "R9");
        // R6: irq follows one cycle later
        cyc(4'b0000, 1'b0, 1'b0, '0, "R6");
        check("R6", {31'b0, irq}, 32'd1);
        // clear, irq drops one cycle later
        cyc(4'b0000, 1'b1, 1'b0, 32'h0000_0020, "R3");
        cyc(4'b0000, 1'b0, 1'b0, '0, "R6");
        check("R6", {31'b0, irq}, 32'd0);
        // R9: status write leaves enable
        peek(1'b1, 32'h0000_01E0, "R9");
        // R8: masked line latches but no irq
        cyc(4'b0000, 1'b1, 1'b1, 32'h0000_0000, "R5");
        cyc(4'b1000, 1'b0, 1'b0, '0, "R8");
        cyc(4'b0000, 1'b0, 1'b0, '0, "R8");
        cyc(4'b0000, 1'b0, 1'b0, '0, "R8");
        check("R8", rdata, 32'h0000_0100);
        check("R8", {31'b0, irq}, 32'd0);

        // random mix, set/clear collisions judged by model
        for (int k = 0; k < 400; k++) begin
            logic          w = ($urandom % 3) == 0;
            logic          s = $urandom % 2;
            logic [N-1:0]  l = (($urandom % 4) == 0) ? N'($urandom) : '0;
            logic [DW-1:0] d = $urandom;
            cyc(l, w, s, d, s ? "R5" : "R2");
            check("R7", rdata & ~(32'hF << SB), '0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule